// File: doc/BRIEF.md
# Serial Light-Sensor ADC Reader

This block is a bus leader that pulls one 8-bit light reading out of a serial successive-approximation ADC that only transmits. A read is started by a one-cycle request on `start_i`. It can also be started by an internal trigger that fires at a fixed interval while `auto_en_i` is high, so the light level is sampled continuously. For each read the block lowers chip select and runs sixteen cycles of a serial clock that idles high (SPI mode 3). It samples the returning data line on every rising edge and then raises chip select again.

The ADC places a few zero bits before its eight data bits, most significant first, and a few zero bits after them. The number of leading zeros can grow by one when chip select falls just before a clock edge. For that reason the byte is taken at a fixed distance from the trailing end of the 16-bit capture. The reading appears on `light_o` together with a one-cycle `light_valid_o` pulse. `busy_o` is high for the whole transfer. The serial clock half-period is a parameter counted in system clocks. It is set so that the line runs between 1 MHz and 4 MHz; for example, 50 at a 200 MHz system clock gives 2 MHz.

Top module: `light_adc_reader`

## Requirements
- R1: While `rst` is high and after it, until a read is started, `adc_cs_n_o` is 1, `adc_sclk_o` is 1, `busy_o` is 0 and `light_valid_o` is 0.
- R2: Whenever `adc_cs_n_o` is 1, `adc_sclk_o` is 1.
- R3: A read holds `adc_cs_n_o` low for exactly 33 × HALF_DIV system cycles. In that window `adc_sclk_o` has exactly 16 rising edges, and each half-period of the serial clock lasts HALF_DIV system cycles.
- R4: After `adc_cs_n_o` falls, the first falling edge of `adc_sclk_o` comes HALF_DIV cycles later. After the last rising edge, `adc_cs_n_o` rises HALF_DIV cycles later.
- R5: `adc_sdata_i` is sampled on each rising edge of `adc_sclk_o`, and the 16 samples form a word whose bit 15 is the first sample. `light_o` is bits 11 down to 4 of that word, which are the 5th to the 12th samples, with bit 11 as the most significant bit.
- R6: The line values in samples 1 to 4 and 13 to 16 have no effect on `light_o`.
- R7: `light_valid_o` is high for exactly one system cycle, in the first cycle in which `adc_cs_n_o` is high again. `light_o` takes the new value in that cycle and holds it until the next read completes.
- R8: `busy_o` is high exactly while `adc_cs_n_o` is low.
- R9: A start request, whether from `start_i` or from the trigger, that arrives while `busy_o` is high is ignored and does not lengthen or repeat the read.
- R10: While `auto_en_i` is high, reads start every TRIG_PERIOD system cycles, so consecutive `light_valid_o` pulses are TRIG_PERIOD cycles apart. TRIG_PERIOD must exceed the read length.
- R11: A dark reading (all data bits 0) gives 0, and a saturated reading (all data bits 1) gives 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request for a single read |
| auto_en_i | input | 1 | Enables the periodic read trigger |
| adc_sdata_i | input | 1 | Serial data from the ADC |
| adc_cs_n_o | output | 1 | ADC chip select, active low |
| adc_sclk_o | output | 1 | Serial clock to the ADC, idles high |
| light_o | output | 8 | Latest light reading |
| light_valid_o | output | 1 | One-cycle pulse when `light_o` is updated |
| busy_o | output | 1 | High while a read is in progress |

## Verification
An ADC model drives every one of the 256 data bytes with zero padding, so each bit position of the extraction is checked against an arithmetic expectation, including the dark and saturated extremes. Frames with all-ones padding around several bytes separate a correct fixed-position extraction from one that is shifted by a bit or that merges padding into the result. Timing is measured on each frame: the length of the chip-select window, the count of rising clock edges and the lead and tail gaps. Single reads with a second request inside the frame show that busy requests are ignored. An automatic run shows that reads occur at the trigger period.

// File: rtl/lar_pkg.sv
package lar_pkg;

  localparam int LAR_FRAME_BITS = 16;
  localparam int LAR_DATA_BITS  = 8;
  localparam int LAR_DATA_LSB   = 4;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LEAD,
    S_SHIFT,
    S_TRAIL
  } lar_state_t;

  // Pull the data byte from a fixed distance off the trailing end of the capture.
  function automatic logic [LAR_DATA_BITS-1:0] lar_take_byte(
      input logic [LAR_FRAME_BITS-1:0] word);
    return word[LAR_DATA_LSB +: LAR_DATA_BITS];
  endfunction

  // Half-period ticks spent with chip select low: lead, 2N-1 edges, tail.
  function automatic int lar_frame_ticks(input int bits);
    return 2 * bits + 1;
  endfunction

endpackage

// File: rtl/lar_half_tick.sv
module lar_half_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  assign tick = run && (cnt == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lar_trigger.sv
module lar_trigger #(
  parameter int PERIOD = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic fire
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [W-1:0] cnt;

  assign fire = en && (cnt == W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (fire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lar_frame_fsm.sv
module lar_frame_fsm
  import lar_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic                      tick,
  input  logic                      sdata,
  output logic                      cs_n,
  output logic                      sclk,
  output logic                      busy,
  output logic                      rise_ev,
  output logic                      fall_ev,
  output logic                      frame_end,
  output logic [LAR_FRAME_BITS-1:0] word
);
  localparam int BW = $clog2(LAR_FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(LAR_FRAME_BITS - 1);

  lar_state_t  st;
  logic [BW-1:0] bitn;
  logic [LAR_FRAME_BITS-1:0] shreg;

  assign busy      = (st != S_IDLE);
  assign rise_ev   = (st == S_SHIFT) && tick && !sclk;
  assign fall_ev   = tick && ((st == S_LEAD) || ((st == S_SHIFT) && sclk));
  assign frame_end = (st == S_TRAIL) && tick;
  assign word      = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cs_n  <= 1'b1;
      sclk  <= 1'b1;
      bitn  <= '0;
      shreg <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (go) begin
            st   <= S_LEAD;
            cs_n <= 1'b0;
            bitn <= '0;
          end
        end
        S_LEAD: begin
          if (tick) begin
            sclk <= 1'b0;
            st   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk  <= 1'b1;
              shreg <= {shreg[LAR_FRAME_BITS-2:0], sdata};
              if (bitn == LAST_BIT) begin
                st <= S_TRAIL;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end else begin
              sclk <= 1'b0;
            end
          end
        end
        S_TRAIL: begin
          if (tick) begin
            cs_n <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/light_adc_reader.sv
module light_adc_reader
  import lar_pkg::*;
#(
  parameter int HALF_DIV    = 50,
  parameter int TRIG_PERIOD = 200000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic                     auto_en_i,
  input  logic                     adc_sdata_i,
  output logic                     adc_cs_n_o,
  output logic                     adc_sclk_o,
  output logic [LAR_DATA_BITS-1:0] light_o,
  output logic                     light_valid_o,
  output logic                     busy_o
);
  logic                      half_tick;
  logic                      trig_fire;
  logic                      start_go;
  logic                      rise_ev;
  logic                      fall_ev;
  logic                      frame_end;
  logic [LAR_FRAME_BITS-1:0] cap_word;

  assign start_go = (start_i || trig_fire) && !busy_o;

  lar_half_tick #(.DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_o),
    .tick (half_tick)
  );

  lar_trigger #(.PERIOD(TRIG_PERIOD)) u_trig (
    .clk  (clk),
    .rst  (rst),
    .en   (auto_en_i),
    .fire (trig_fire)
  );

  lar_frame_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .go        (start_go),
    .tick      (half_tick),
    .sdata     (adc_sdata_i),
    .cs_n      (adc_cs_n_o),
    .sclk      (adc_sclk_o),
    .busy      (busy_o),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .frame_end (frame_end),
    .word      (cap_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      light_o       <= '0;
      light_valid_o <= 1'b0;
    end else begin
      light_valid_o <= frame_end;
      if (frame_end) begin
        light_o <= lar_take_byte(cap_word);
      end
    end
  end
endmodule

// File: rtl/lar_checker.sv
module lar_checker #(
  parameter int HALF_DIV = 50
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic valid,
  input logic half_tick,
  input logic rise_ev,
  input logic fall_ev,
  input logic frame_end
);
  logic       sclk_d;
  logic [4:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b1;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n) begin
        rise_cnt <= '0;
      end else if (sclk && !sclk_d) begin
        rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  p_sclk_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  p_sixteen_rises_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rise_cnt == 5'd16));

  p_sclk_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> $past(half_tick));

  p_rise_event_r5: assert property (@(posedge clk) disable iff (rst)
    rise_ev |=> sclk);

  p_fall_event_r4: assert property (@(posedge clk) disable iff (rst)
    fall_ev |=> (!sclk && !cs_n));

  p_valid_at_release_r7: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (valid && cs_n));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_busy_tracks_cs_r8: assert property (@(posedge clk) disable iff (rst)
    busy == !cs_n);

  p_start_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(!busy));
endmodule

bind light_adc_reader lar_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (adc_cs_n_o),
  .sclk      (adc_sclk_o),
  .busy      (busy_o),
  .valid     (light_valid_o),
  .half_tick (half_tick),
  .rise_ev   (rise_ev),
  .fall_ev   (fall_ev),
  .frame_end (frame_end)
);

// File: tb/light_adc_reader_tb.sv
`timescale 1ns/1ps
module light_adc_reader_tb;
  localparam int HALF   = 2;
  localparam int PERIOD = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       auto_en_i = 1'b0;
  logic       adc_sdata_i = 1'b0;
  logic       adc_cs_n_o, adc_sclk_o, light_valid_o, busy_o;
  logic [7:0] light_o;

  always #2.5 clk = ~clk;

  light_adc_reader #(.HALF_DIV(HALF), .TRIG_PERIOD(PERIOD)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .auto_en_i(auto_en_i),
    .adc_sdata_i(adc_sdata_i), .adc_cs_n_o(adc_cs_n_o), .adc_sclk_o(adc_sclk_o),
    .light_o(light_o), .light_valid_o(light_valid_o), .busy_o(busy_o)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ADC model: a new bit is put on the line at each falling serial clock edge.
  logic [15:0] adc_word = 16'h0;
  int          adc_idx  = 0;
  always @(negedge adc_cs_n_o) adc_idx = 0;
  always @(negedge adc_sclk_o) begin
    if (!adc_cs_n_o && adc_idx < 16) begin
      adc_sdata_i = adc_word[15 - adc_idx];
      adc_idx++;
    end
  end

  // Monitor, sampling away from the active edge.
  int cyc = 0, low_cnt = 0, rises = 0, tail = 0, fgap = 0, seen_fall = 0;
  int frames = 0, f_len = 0, f_rises = 0, f_fgap = 0, f_tail = 0, f_valid = 0;
  int valid_total = 0, last_vcyc = -1, last_interval = 0;
  int idle_err = 0, busy_err = 0, valid_len_err = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (adc_cs_n_o && !adc_sclk_o) idle_err++;
      if (busy_o !== !adc_cs_n_o) busy_err++;
      if (light_valid_o && prev_valid) valid_len_err++;
      if (light_valid_o) begin
        valid_total++;
        if (last_vcyc >= 0) last_interval = cyc - last_vcyc;
        last_vcyc = cyc;
      end
      if (!adc_cs_n_o) begin
        if (prev_sclk && !adc_sclk_o && !seen_fall) begin
          fgap = low_cnt;
          seen_fall = 1;
        end
        if (!prev_sclk && adc_sclk_o) begin
          rises++;
          tail = 1;
        end else if (adc_sclk_o) begin
          tail++;
        end
        low_cnt++;
      end else if (!prev_cs) begin
        f_len = low_cnt; f_rises = rises; f_fgap = fgap; f_tail = tail;
        f_valid = light_valid_o;
        frames++;
        low_cnt = 0; rises = 0; tail = 0; seen_fall = 0;
      end
    end
    prev_cs = adc_cs_n_o;
    prev_sclk = adc_sclk_o;
    prev_valid = light_valid_o;
  end

  task automatic wait_frame(input int f0);
    while (frames == f0) @(negedge clk);
  endtask

  task automatic one_read(input logic [15:0] w, input logic [7:0] exp,
                          input string req, input bit timing);
    int f0;
    adc_word = w;
    f0 = frames;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_frame(f0);
    chk(light_o == exp, req, "light value", light_o, exp);
    chk(f_valid == 1, "R7", "valid at cs release", f_valid, 1);
    if (timing) begin
      chk(f_len == 33 * HALF, "R3", "cs low cycles", f_len, 33 * HALF);
      chk(f_rises == 16, "R3", "rising edges", f_rises, 16);
      chk(f_fgap == HALF, "R4", "lead gap", f_fgap, HALF);
      chk(f_tail == HALF, "R4", "tail gap", f_tail, HALF);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(adc_cs_n_o && adc_sclk_o && !busy_o && !light_valid_o, "R1",
        "outputs in reset", {adc_cs_n_o, adc_sclk_o, busy_o, light_valid_o}, 4'b1100);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(adc_cs_n_o && adc_sclk_o && !busy_o && !light_valid_o, "R1",
        "outputs idle after reset", {adc_cs_n_o, adc_sclk_o, busy_o, light_valid_o}, 4'b1100);

    // R11: extremes
    one_read(16'h0000, 8'h00, "R11", 1'b1);
    one_read(16'h0FF0, 8'hFF, "R11", 1'b1);

    // R5: every byte with zero padding
    for (int b = 0; b < 256; b++) begin
      one_read({4'h0, 8'(b), 4'h0}, 8'(b), "R5", (b % 32) == 0);
    end

    // R6: padding positions have no effect
    one_read({4'hF, 8'hA5, 4'hF}, 8'hA5, "R6", 1'b0);
    one_read({4'hA, 8'h00, 4'h5}, 8'h00, "R6", 1'b0);
    one_read({4'h9, 8'h3C, 4'h6}, 8'h3C, "R6", 1'b0);
    one_read({4'hF, 8'h81, 4'h0}, 8'h81, "R6", 1'b0);

    // R7: value held and valid low afterwards
    repeat (20) @(negedge clk);
    chk(light_o == 8'h81, "R7", "value held", light_o, 8'h81);
    chk(!light_valid_o, "R7", "valid low after pulse", light_valid_o, 0);

    // R9: start while busy ignored
    begin
      int f0;
      adc_word = {4'h0, 8'h5A, 4'h0};
      f0 = frames;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (10) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      wait_frame(f0);
      chk(f_len == 33 * HALF, "R9", "frame length with busy start", f_len, 33 * HALF);
      repeat (40) @(negedge clk);
      chk(frames == f0 + 1, "R9", "frames started", frames - f0, 1);
      chk(!busy_o, "R9", "idle after ignored start", busy_o, 0);
      chk(light_o == 8'h5A, "R9", "value", light_o, 8'h5A);
    end

    // R10: periodic trigger
    begin
      int v0;
      adc_word = {4'h0, 8'hC3, 4'h0};
      v0 = valid_total;
      @(negedge clk); auto_en_i = 1'b1;
      while (valid_total < v0 + 2) @(negedge clk);
      chk(last_interval == PERIOD, "R10", "trigger interval", last_interval, PERIOD);
      while (valid_total < v0 + 3) @(negedge clk);
      chk(last_interval == PERIOD, "R10", "trigger interval", last_interval, PERIOD);
      chk(light_o == 8'hC3, "R10", "auto value", light_o, 8'hC3);
      auto_en_i = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (2 * PERIOD) @(negedge clk);
      chk(valid_total == v0 + 3, "R10", "no reads with trigger off", valid_total - v0, 3);
    end

    chk(idle_err == 0, "R2", "sclk low while deselected", idle_err, 0);
    chk(busy_err == 0, "R8", "busy vs cs mismatches", busy_err, 0);
    chk(valid_len_err == 0, "R7", "valid longer than one cycle", valid_len_err, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule